// File: doc/BRIEF.md
# Mode-Flag Register and Accumulator Load Unit

This block belongs to a DSP core. It holds a 16-bit status word that carries three mode bits. It also holds one 40-bit accumulator, split into an 8-bit top part, a 16-bit middle word and a 16-bit bottom word. Short flag opcodes set or clear each mode bit. A load-immediate request writes a 16-bit value into one part of the accumulator.

One mode bit picks the width mode. When that bit is set (16-bit mode), a load into the middle word sign-extends the value across the whole accumulator. When it is clear (40-bit mode), the same load writes only the middle word. A second mode bit drives a scale-by-two flag for an external multiplier. The third mode bit is stored and reported only.

Top module: `mode_acc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is `status_out` = 0x2000, `acc_out` = 0 and `mul_double` = 0.
- R2: A flag opcode has `insn_valid` high and its selector in `insn_word[11:8]`. Selector 0xA clears status bit 13. Selector 0xB sets status bit 13.
- R3: `mul_double` is 1 exactly when status bit 13 is 0.
- R4: Selector 0xC clears status bit 15. Selector 0xD sets status bit 15.
- R5: Selector 0xE clears status bit 14, which selects 40-bit mode. Selector 0xF sets status bit 14, which selects 16-bit mode.
- R6: The status word does not change on a selector below 0xA, or when `insn_valid` is low. Status bits 12 to 0 always read 0. The other bits of `insn_word` have no effect.
- R7: With status bit 14 set, a load with `ld_part` = 1 (middle word) gives `acc_out` = {8 copies of value bit 15, value, 16'h0000}.
- R8: With status bit 14 clear, a load with `ld_part` = 1 writes only `acc_out[31:16]`. Bits [39:32] and [15:0] keep their values.
- R9: In both modes, `ld_part` = 0 writes `ld_value` into `acc_out[15:0]` and nothing else. `ld_part` = 2 writes `ld_value[7:0]` into `acc_out[39:32]` and nothing else. `ld_part` = 3 changes nothing.
- R10: Every update appears after the rising edge that samples its request. When a flag opcode and a load arrive in the same cycle, the load uses the value of status bit 14 from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Flag opcode strobe |
| insn_word | input | 16 | Instruction word; the selector is in bits [11:8] |
| ld_valid | input | 1 | Load-immediate strobe |
| ld_part | input | 2 | Target part: 0 = bottom, 1 = middle, 2 = top, 3 = none |
| ld_value | input | 16 | Immediate value |
| status_out | output | 16 | Status word |
| acc_out | output | 40 | Full accumulator |
| mul_double | output | 1 | Multiplier scale-by-two flag |

## Verification
The bench loads the middle word with values that have bit 15 set and with values that have it clear, in both modes. A design that ignored the mode would leave stale top and bottom parts in 16-bit mode, or would wipe them in 40-bit mode.

The bench also issues a mode change and a middle-word load in the same cycle, in both directions. A design that let the new mode bypass the register would sign-extend when it should not, or fail to sign-extend when it should.

Selectors below 0xA, opcodes with the strobe low, and reserved part code 3 are all applied. A design with loose decoding would change a mode bit or corrupt the accumulator on these inputs. A random phase with mid-run resets then compares every output on every clock.

// File: rtl/mode_acc_pkg.sv
// Shared constants and types for the mode-flag / accumulator unit.
// Assumes selector pairs are laid out as clear, set for consecutive codes.
package mode_acc_pkg;
    localparam int DATA_W  = 16;
    localparam int HI_W    = 8;
    localparam int ACC_W   = HI_W + 2 * DATA_W;
    localparam int N_MODE  = 3;
    localparam int SEL_W   = 4;
    localparam logic [SEL_W-1:0] SEL_BASE = 4'hA;
    // Status bit position for each mode pair index: 0 -> mul, 1 -> bit15, 2 -> width
    localparam int MUL_POS = 13;
    localparam int B15_POS = 15;
    localparam int EXT_POS = 14;
    // Mode vector index of the sign-extension (16-bit mode) bit
    localparam int EXT_IDX = 2;
    localparam int MUL_IDX = 0;
    localparam logic [N_MODE-1:0] MODE_RST = 3'b001;

    typedef enum logic [1:0] {
        PART_LO   = 2'd0,
        PART_MID  = 2'd1,
        PART_HI   = 2'd2,
        PART_NONE = 2'd3
    } acc_part_e;
endpackage

// File: rtl/flag_decode.sv
// Decodes the flag selector into per-mode-bit set and clear strobes.
// Assumes pair k uses code SEL_BASE+2k for clear and SEL_BASE+2k+1 for set.
module flag_decode
    import mode_acc_pkg::*;
#(
    parameter int NM = N_MODE,
    parameter int SW = SEL_W
) (
    input  logic          valid,
    input  logic [SW-1:0] sel,
    output logic [NM-1:0] set_v,
    output logic [NM-1:0] clr_v
);
    for (genvar k = 0; k < NM; k++) begin : g_pair
        localparam logic [SW-1:0] CLR_CODE = SW'(SEL_BASE + 2 * k);
        localparam logic [SW-1:0] SET_CODE = SW'(SEL_BASE + 2 * k + 1);
        // Raise the strobe for this pair's matching code
        always_comb begin
            clr_v[k] = valid && (sel == CLR_CODE);
            set_v[k] = valid && (sel == SET_CODE);
        end
    end
endmodule

// File: rtl/mode_bits.sv
// Holds the mode bits; each is set or cleared by its own strobe.
// Assumes set and clear of the same bit never arrive together (set wins).
module mode_bits
    import mode_acc_pkg::*;
#(
    parameter int NM = N_MODE,
    parameter logic [NM-1:0] RST_VAL = MODE_RST
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] set_v,
    input  logic [NM-1:0] clr_v,
    output logic [NM-1:0] mode_q
);
    for (genvar k = 0; k < NM; k++) begin : g_bit
        // Update one mode bit from its strobes
        always_ff @(posedge clk) begin
            if (!rst_n)          mode_q[k] <= RST_VAL[k];
            else if (set_v[k])   mode_q[k] <= 1'b1;
            else if (clr_v[k])   mode_q[k] <= 1'b0;
        end

        a_r2_set_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (set_v[k] || clr_v[k]) |=> (mode_q[k] == $past(set_v[k])));
    end
endmodule

// File: rtl/acc_bank.sv
// 40-bit accumulator made of top, middle and bottom parts with immediate load.
// Assumes middle and bottom parts are as wide as the load value.
module acc_bank
    import mode_acc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int HW = HI_W,
    localparam int AW = HW + 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  acc_part_e     ld_part,
    input  logic [DW-1:0] ld_value,
    input  logic          ext_mode,
    output logic [AW-1:0] acc_q
);
    logic [HW-1:0] hi_q;
    logic [DW-1:0] mid_q;
    logic [DW-1:0] lo_q;

    // Write the selected part; a middle load in extend mode rewrites all parts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            mid_q <= '0;
            lo_q  <= '0;
        end else if (ld_valid) begin
            case (ld_part)
                PART_LO:  lo_q <= ld_value;
                PART_HI:  hi_q <= ld_value[HW-1:0];
                PART_MID: begin
                    mid_q <= ld_value;
                    if (ext_mode) begin
                        hi_q <= {HW{ld_value[DW-1]}};
                        lo_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Present the parts as one accumulator word
    assign acc_q = {hi_q, mid_q, lo_q};

    a_r7_mid_extend: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_part == PART_MID && ext_mode)
        |=> (acc_q == {{HW{$past(ld_value[DW-1])}}, $past(ld_value), {DW{1'b0}}}));

    a_r8_mid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_part == PART_MID && !ext_mode)
        |=> (acc_q[AW-1:2*DW] == $past(acc_q[AW-1:2*DW])
             && acc_q[DW-1:0] == $past(acc_q[DW-1:0])
             && acc_q[2*DW-1:DW] == $past(ld_value)));

    a_r9_none_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_valid || ld_part == PART_NONE) |=> $stable(acc_q));
endmodule

// File: rtl/mode_acc_unit.sv
// Top: flag opcodes update three mode bits in a status word; load-immediate
// writes the accumulator, with middle loads sign-extending in 16-bit mode.
// Assumes the caller strobes insn_valid only for flag opcodes.
module mode_acc_unit
    import mode_acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [15:0]       insn_word,
    input  logic              ld_valid,
    input  logic [1:0]        ld_part,
    input  logic [DATA_W-1:0] ld_value,
    output logic [15:0]       status_out,
    output logic [ACC_W-1:0]  acc_out,
    output logic              mul_double
);
    logic [N_MODE-1:0] set_v;
    logic [N_MODE-1:0] clr_v;
    logic [N_MODE-1:0] mode_q;
    logic              unused_insn_bits;

    // Only the selector field takes part in decoding
    assign unused_insn_bits = ^{insn_word[15:12], insn_word[7:0]};

    flag_decode #(.NM(N_MODE), .SW(SEL_W)) u_dec (
        .valid (insn_valid),
        .sel   (insn_word[11:8]),
        .set_v (set_v),
        .clr_v (clr_v)
    );

    mode_bits #(.NM(N_MODE), .RST_VAL(MODE_RST)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (set_v),
        .clr_v  (clr_v),
        .mode_q (mode_q)
    );

    acc_bank #(.DW(DATA_W), .HW(HI_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_valid (ld_valid),
        .ld_part  (acc_part_e'(ld_part)),
        .ld_value (ld_value),
        .ext_mode (mode_q[EXT_IDX]),
        .acc_q    (acc_out)
    );

    // Place the mode bits at their status positions; other bits read zero
    always_comb begin
        status_out          = '0;
        status_out[MUL_POS] = mode_q[0];
        status_out[B15_POS] = mode_q[1];
        status_out[EXT_POS] = mode_q[2];
    end

    // Multiplier doubles its product while the mul mode bit is clear
    assign mul_double = ~mode_q[MUL_IDX];

    a_r6_bad_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!insn_valid || insn_word[11:8] < SEL_BASE) |=> $stable(status_out));

    a_r5_set16: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[11:8] == 4'hF) |=> status_out[14]);

    a_r4_clr15: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[11:8] == 4'hC) |=> !status_out[15]);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (status_out == 16'h2000 && acc_out == '0 && mul_double == 1'b0));
endmodule

// File: tb/sim_mode_acc_unit.sv
module sim_mode_acc_unit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        insn_valid = 0;
    logic [15:0] insn_word = '0;
    logic        ld_valid = 0;
    logic [1:0]  ld_part = '0;
    logic [15:0] ld_value = '0;
    logic [15:0] status_out;
    logic [39:0] acc_out;
    logic        mul_double;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_st = 16'h2000;
    logic [39:0] m_acc = '0;

    always #5 clk = ~clk;

    mode_acc_unit u0 (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_word(insn_word),
        .ld_valid(ld_valid), .ld_part(ld_part), .ld_value(ld_value),
        .status_out(status_out), .acc_out(acc_out), .mul_double(mul_double)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_st = 16'h2000;
            m_acc = '0;
        end else begin
            if (ld_valid) begin
                if (ld_part == 2'd0) m_acc[15:0] = ld_value;
                else if (ld_part == 2'd2) m_acc[39:32] = ld_value[7:0];
                else if (ld_part == 2'd1) begin
                    if (m_st[14]) m_acc = {{8{ld_value[15]}}, ld_value, 16'h0000};
                    else m_acc[31:16] = ld_value;
                end
            end
            if (insn_valid) begin
                case (insn_word[11:8])
                    4'hA: m_st[13] = 1'b0;
                    4'hB: m_st[13] = 1'b1;
                    4'hC: m_st[15] = 1'b0;
                    4'hD: m_st[15] = 1'b1;
                    4'hE: m_st[14] = 1'b0;
                    4'hF: m_st[14] = 1'b1;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (status_out !== m_st) begin
            failures++;
            $display("FAIL %s status got %h exp %h", tag, status_out, m_st);
        end
        checks++;
        if (acc_out !== m_acc) begin
            failures++;
            $display("FAIL %s acc got %h exp %h", tag, acc_out, m_acc);
        end
        checks++;
        if (mul_double !== ~m_st[13]) begin
            failures++;
            $display("FAIL %s (R3) mul_double got %b exp %b", tag, mul_double, ~m_st[13]);
        end
    endtask

    // drive one cycle of inputs at negedge, advance model at posedge, compare at next negedge
    task automatic step(input logic rs, input logic iv, input logic [3:0] sel,
                        input logic lv, input logic [1:0] lp, input logic [15:0] val,
                        input string tag);
        rst_n = rs;
        insn_valid = iv;
        insn_word = {4'h5, sel, 8'hC3};
        ld_valid = lv;
        ld_part = lp;
        ld_value = val;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic flag(input logic [3:0] sel, input string tag);
        step(1, 1, sel, 0, 2'd0, 16'h0, tag);
    endtask

    task automatic load(input logic [1:0] lp, input logic [15:0] val, input string tag);
        step(1, 0, 4'h0, 1, lp, val, tag);
    endtask

    initial begin
        @(negedge clk);
        step(0, 1, 4'hF, 1, 2'd1, 16'hFFFF, "R1 reset");
        step(0, 0, 4'h0, 0, 2'd0, 16'h0, "R1 reset");
        // mode bit pairs
        flag(4'hA, "R2 clear b13");
        flag(4'hB, "R2 set b13");
        flag(4'hA, "R3 doubled");
        flag(4'hD, "R4 set b15");
        flag(4'hC, "R4 clr b15");
        flag(4'hF, "R5 set16");
        flag(4'hE, "R5 set40");
        // ignored selectors and strobe low
        flag(4'h0, "R6 sel 0");
        flag(4'h9, "R6 sel 9");
        step(1, 0, 4'hB, 0, 2'd0, 16'h0, "R6 strobe low");
        // 40-bit mode loads
        load(2'd2, 16'h5512, "R9 hi 40");
        load(2'd0, 16'hBEEF, "R9 lo 40");
        load(2'd1, 16'h8001, "R8 mid 40");
        load(2'd3, 16'h1234, "R9 none");
        // 16-bit mode loads
        flag(4'hF, "R5 set16");
        load(2'd1, 16'h8001, "R7 mid neg");
        load(2'd0, 16'h1357, "R9 lo 16");
        load(2'd1, 16'h7FFF, "R7 mid pos");
        load(2'd2, 16'h00AB, "R9 hi 16");
        load(2'd3, 16'hFFFF, "R9 none 16");
        // same-cycle mode change and load
        step(1, 1, 4'hE, 1, 2'd1, 16'h9000, "R10 set40+mid");
        load(2'd0, 16'h4444, "R9 lo");
        step(1, 1, 4'hF, 1, 2'd1, 16'hA5A5, "R10 set16+mid");
        load(2'd1, 16'hC001, "R10 new mode used");
        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [3:0] s;
            s = 4'($urandom_range(0, 15));
            step(($urandom_range(0, 39) != 0), 1'($urandom), s, 1'($urandom),
                 2'($urandom), 16'($urandom), "R10 random");
        end
        step(0, 0, 4'h0, 0, 2'd0, 16'h0, "R1 late reset");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired (R10 progress)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule